// File: doc/BRIEF.md
# Serial-Chain Bus Arbiter

This block shares one bus among a parameterised number of masters that are wired in a serial chain behind a host. Each master raises a request line when it wants the bus. The block merges all demand into a single hold request towards the host. It then takes the host's single acknowledge and passes it along the chain. An acknowledge passes through every position that is neither requesting nor using the bus. It stops at the first position that is.

Priority follows position. Index 0 sits next to the host and wins over every higher index. Once a master has taken the bus it keeps it until it drops its own request. This holds even if a master closer to the host starts asking later. A master's grant output is high while it owns the bus and the host acknowledge is present.

Top module: `dchain_arbiter`

## Requirements
- R1: `host_hold` is high in any cycle where at least one `mreq` bit or one `mbusy` bit is set, and low otherwise.
- R2: With `host_ack` high and no master busy, the requesting master with the lowest index becomes busy at the next clock edge. Index 0 is nearest the host.
- R3: While any master is busy, no other master becomes busy. A farther requester waits until the busy one releases.
- R4: A busy master stays busy while its request stays high, even when a closer master starts requesting.
- R5: A busy master's `mbusy` bit clears at the first edge where its `mreq` bit is low. Another requester can win no earlier than the following edge.
- R6: `mgrant` equals `mbusy` while `host_ack` is high and is all zero while `host_ack` is low. A busy master stays busy through a low `host_ack`.
- R7: At most one bit of `mgrant`, and at most one bit of `mbusy`, is set in any cycle.
- R8: Asserting `rst_n` low clears `mbusy` and `mgrant` at once. With no requests, `host_hold` is then low.
- R9: A request made while `host_ack` is low makes no master busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| mreq | input | N_MASTERS | Per-master bus request; bit 0 is closest to the host |
| host_ack | input | 1 | Acknowledge from the host |
| host_hold | output | 1 | Merged hold request to the host |
| mgrant | output | N_MASTERS | Per-master grant |
| mbusy | output | N_MASTERS | Per-master bus-in-use flag |

## Verification
The bench builds the arbiter with the default of four masters. With four masters, a requester can stand at a middle position, with idle positions on both sides of it. That covers several cases: a closer master arriving after a farther one already holds the bus, a farther master waiting behind a closer owner, and a hand-over from one owner to the next. The bench also covers an owner holding the bus through an acknowledge gap, and an asynchronous reset taken while a master owns the bus.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  // default chain length
  localparam int unsigned DCHAIN_DEF_MASTERS = 4;
  // reset synchroniser depth
  localparam int unsigned DCHAIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync #(
  parameter int unsigned STAGES = dchain_pkg::DCHAIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/dchain_ripple.sv
module dchain_ripple #(
  parameter int unsigned N_MASTERS = dchain_pkg::DCHAIN_DEF_MASTERS
) (
  input  logic                 host_ack,
  input  logic [N_MASTERS-1:0] mreq,
  input  logic [N_MASTERS-1:0] busy,
  output logic [N_MASTERS-1:0] ack_at
);
  // acknowledge seen by each position; an idle position passes it on
  assign ack_at[0] = host_ack;
  for (genvar g = 1; g < N_MASTERS; g++) begin : g_pass
    assign ack_at[g] = ack_at[g-1] & ~mreq[g-1] & ~busy[g-1];
  end
endmodule

// File: rtl/dchain_link.sv
module dchain_link (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic want,
  input  logic any_busy,
  input  logic host_ack,
  output logic busy_q,
  output logic grant
);
  logic busy_d;
  logic busy_en;

  always_comb begin
    busy_en = busy_q | (want & ack_in);
    if (busy_q) busy_d = want;
    else        busy_d = want & ack_in & ~any_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign grant = busy_q & host_ack;
endmodule

// File: rtl/dchain_arbiter.sv
module dchain_arbiter #(
  parameter int unsigned N_MASTERS = dchain_pkg::DCHAIN_DEF_MASTERS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] mreq,
  input  logic                 host_ack,
  output logic                 host_hold,
  output logic [N_MASTERS-1:0] mgrant,
  output logic [N_MASTERS-1:0] mbusy
);
  logic                 rst_int_n;
  logic [N_MASTERS-1:0] ack_at;
  logic [N_MASTERS-1:0] busy_w;
  logic                 any_busy;

  dchain_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dchain_ripple #(.N_MASTERS(N_MASTERS)) u_ripple (
    .host_ack (host_ack),
    .mreq     (mreq),
    .busy     (busy_w),
    .ack_at   (ack_at)
  );

  assign any_busy = |busy_w;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_link
    dchain_link u_link (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .ack_in   (ack_at[g]),
      .want     (mreq[g]),
      .any_busy (any_busy),
      .host_ack (host_ack),
      .busy_q   (busy_w[g]),
      .grant    (mgrant[g])
    );
  end

  assign mbusy     = busy_w;
  assign host_hold = (|mreq) | any_busy;
endmodule

// File: rtl/dchain_arbiter_chk.sv
module dchain_arbiter_chk #(
  parameter int unsigned N_MASTERS = dchain_pkg::DCHAIN_DEF_MASTERS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] mreq,
  input logic                 host_ack,
  input logic                 host_hold,
  input logic [N_MASTERS-1:0] mgrant,
  input logic [N_MASTERS-1:0] mbusy
);
  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mgrant) && $onehot0(mbusy));

  assert_grant_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ack |-> (mgrant == '0));

  assert_busy_raises_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mbusy != '0) |-> host_hold);

  assert_no_steal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbusy != '0) |=> ((mbusy & ~$past(mbusy)) == '0));

  assert_owner_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mbusy & mreq) != '0) |=> ((mbusy & $past(mbusy & mreq)) == $past(mbusy & mreq)));

  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mbusy & ~mreq) != '0) |=> ((mbusy & $past(mbusy & ~mreq)) == '0));

  assert_no_ack_no_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ack && mbusy == '0) |=> (mbusy == '0));
endmodule

bind dchain_arbiter dchain_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (.*);

// File: tb/test_dchain_arbiter.sv
module test_dchain_arbiter;
  localparam int unsigned NM = 4;

  typedef struct packed {
    logic [NM-1:0] busy;
    logic [NM-1:0] grant;
    logic          hold;
    logic [7:0]    tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [NM-1:0] mreq;
  logic          host_ack;
  logic          host_hold;
  logic [NM-1:0] mgrant;
  logic [NM-1:0] mbusy;

  exp_t sb_q[$];
  int   n_cmp;
  int   n_bad;
  bit   done;

  dchain_arbiter #(.N_MASTERS(NM)) i_dchain_arbiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreq      (mreq),
    .host_ack  (host_ack),
    .host_hold (host_hold),
    .mgrant    (mgrant),
    .mbusy     (mbusy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: apply inputs at negedge, queue what must show after the next edge
  task automatic step(input logic [NM-1:0] r, input logic a,
                      input logic [NM-1:0] eb, input logic [NM-1:0] eg,
                      input logic eh, input logic [7:0] tg);
    exp_t e;
    @(negedge clk);
    mreq     = r;
    host_ack = a;
    e.busy = eb; e.grant = eg; e.hold = eh; e.tag = tg;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      n_cmp++;
      if ($countones(mgrant) > 1) begin
        n_bad++;
        $display("FAIL R7 mgrant=%b expected at most one bit set", mgrant);
      end
    end
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (mbusy !== e.busy || mgrant !== e.grant || host_hold !== e.hold) begin
        n_bad++;
        $display("FAIL R%0d: busy=%b grant=%b hold=%b expected busy=%b grant=%b hold=%b",
                 e.tag, mbusy, mgrant, host_hold, e.busy, e.grant, e.hold);
      end
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    mreq = '0; host_ack = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    n_cmp++;
    if (mbusy !== '0 || mgrant !== '0 || host_hold !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 busy=%b grant=%b hold=%b expected 0 0 0", mbusy, mgrant, host_hold);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 8);  // R8 idle after reset
    step(4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 9);  // R9 no ack, no owner; R1 hold
    step(4'b0110, 1'b1, 4'b0010, 4'b0010, 1'b1, 2);  // R2 lowest index wins
    step(4'b0111, 1'b1, 4'b0010, 4'b0010, 1'b1, 4);  // R4 closer late request
    step(4'b0111, 1'b0, 4'b0010, 4'b0000, 1'b1, 6);  // R6 ack gap keeps owner
    step(4'b0101, 1'b1, 4'b0000, 4'b0000, 1'b1, 5);  // R5 release
    step(4'b0101, 1'b1, 4'b0001, 4'b0001, 1'b1, 2);  // R2 next winner is index 0
    step(4'b0100, 1'b1, 4'b0000, 4'b0000, 1'b1, 5);  // R5 release
    step(4'b0100, 1'b1, 4'b0100, 4'b0100, 1'b1, 3);  // R3 waiting master wins
    step(4'b1100, 1'b1, 4'b0100, 4'b0100, 1'b1, 3);  // R3 farther blocked
    step(4'b1000, 1'b1, 4'b0000, 4'b0000, 1'b1, 5);
    step(4'b1000, 1'b1, 4'b1000, 4'b1000, 1'b1, 2);  // R2 last position
    step(4'b0000, 1'b1, 4'b0000, 4'b0000, 1'b0, 1);  // R1 hold drops
    step(4'b0001, 1'b1, 4'b0001, 4'b0001, 1'b1, 2);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;  // R8: asynchronous clear while owned
    #1;
    n_cmp++;
    if (mbusy !== '0 || mgrant !== '0) begin
      n_bad++;
      $display("FAIL R8 busy=%b grant=%b expected 0000 0000", mbusy, mgrant);
    end
    mreq = '0;
    #1;
    n_cmp++;
    if (host_hold !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 hold=%b expected 0", host_hold);
    end
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule